// File: doc/BRIEF.md
# Branch Target Buffer

The block holds the targets of recently taken branches in a set-associative array. The fetch stage looks it up with the current fetch address. In the same cycle it returns a hit flag, the stored target, a taken indication and the address to fetch next. When the lookup misses, the next fetch address is the fetch address plus 4. When it hits, the stored target is used. The taken indication comes from one of two sources, chosen by a mode input: the hit alone, or the hit combined with a direction prediction supplied from outside.

At branch resolution the back end drives the update port. A resolved taken branch refreshes the target of a matching entry. If no entry matches, it allocates one: an invalid way if the set has any, otherwise the least recently used way. A resolved not-taken branch that matches an entry removes that entry when the parameter `INV_ON_NT` is set. A lookup hit with a valid request and an update both mark the way they touch as most recently used.

Top module: `btb_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lk_hit`=0, `lk_taken`=0 and `lk_next_pc`=`lk_pc`+4.
- R2: A lookup that matches no valid entry gives `lk_hit`=0, `lk_taken`=0 and `lk_next_pc`=`lk_pc`+4 in the same cycle. When `lk_valid`=0 the outputs also read as a miss.
- R3: When `lk_use_dir`=0, a hit gives `lk_taken`=1 and `lk_next_pc` equal to the stored target, with no clock cycle of latency.
- R4: When `lk_use_dir`=1, a hit still gives `lk_hit`=1. The stored target is fetched next only if `lk_dir_taken`=1. If `lk_dir_taken`=0, then `lk_taken`=0 and `lk_next_pc`=`lk_pc`+4.
- R5: A taken update to an address that misses installs the entry. A lookup of that address in the following cycle hits and returns the new target.
- R6: A taken update to an address that hits overwrites the stored target. Later lookups return the new target.
- R7: With `INV_ON_NT`=1 (the default), a not-taken update that hits clears the entry, and later lookups of that address miss.
- R8: The set is selected by address bits [2+log2(SETS)-1:2], and the tag is taken from the bits above them. Up to WAYS branches that share a set index but differ in tag are held at the same time.
- R9: When a full set receives a taken update that misses, the update replaces the least recently used way. A lookup hit with `lk_valid`=1 counts as a use.
- R10: Allocation takes an invalid way of the set before it evicts any valid way.
- R11: A lookup with `lk_valid`=0 does not change the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | ADDR_W | Fetch address being looked up |
| lk_use_dir | input | 1 | 1: qualify a hit with `lk_dir_taken`; 0: a hit alone predicts taken |
| lk_dir_taken | input | 1 | Direction prediction from outside the block |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_taken | output | 1 | Redirect fetch to the stored target |
| lk_target | output | ADDR_W | Stored target of the matching way |
| lk_next_pc | output | ADDR_W | Next fetch address |
| up_valid | input | 1 | Resolved branch update this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | ADDR_W | Resolved target |

## Verification
The assertions assume word-aligned addresses on both ports. They also assume that every input holds a known value on each clock edge once reset is released. The bench keeps to these assumptions: it drives only multiples of 4, and it sets every input to a defined level during reset. It changes inputs only on the falling edge and lowers each request again right after the rising edge that consumes it. As a result, no lookup or update stays active for a second cycle and disturbs the recency order that the eviction checks depend on.

// File: rtl/btb_cache.sv
module btb_cache #(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter bit INV_ON_NT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_use_dir,
  input  logic              lk_dir_taken,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic              vld_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rank_q [SETS][WAYS];

  wire [IDX_W-1:0] lk_idx = lk_pc[2 +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] up_idx = up_pc[2 +: IDX_W];
  wire [TAG_W-1:0] up_tag = up_pc[ADDR_W-1 -: TAG_W];

  logic             lk_found, up_found, free_found;
  logic [WAY_W-1:0] lk_way, up_way, free_way, old_way, fill_way;

  always_comb begin
    lk_found = 1'b0; lk_way = '0;
    up_found = 1'b0; up_way = '0;
    free_found = 1'b0; free_way = '0;
    old_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
        lk_found = 1'b1; lk_way = WAY_W'(w);
      end
      if (vld_q[up_idx][w] && tag_q[up_idx][w] == up_tag) begin
        up_found = 1'b1; up_way = WAY_W'(w);
      end
      if (!vld_q[up_idx][w]) begin
        free_found = 1'b1; free_way = WAY_W'(w);
      end
      if (rank_q[up_idx][w] == OLDEST) old_way = WAY_W'(w);
    end
    fill_way = up_found ? up_way : (free_found ? free_way : old_way);
  end

  assign lk_hit     = lk_valid && lk_found;
  assign lk_target  = tgt_q[lk_idx][lk_way];
  assign lk_taken   = lk_hit && (!lk_use_dir || lk_dir_taken);
  assign lk_next_pc = lk_taken ? lk_target : lk_pc + ADDR_W'(4);

  wire up_write = up_valid && up_taken;
  wire up_kill  = up_valid && !up_taken && up_found && INV_ON_NT;
  wire lk_touch = lk_hit && !(up_write && up_idx == lk_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          tag_q[s][w]  <= '0;
          tgt_q[s][w]  <= '0;
          rank_q[s][w] <= WAY_W'(w);
        end
    end else begin
      if (up_write) begin
        vld_q[up_idx][fill_way] <= 1'b1;
        tag_q[up_idx][fill_way] <= up_tag;
        tgt_q[up_idx][fill_way] <= up_target;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == fill_way)
            rank_q[up_idx][w] <= '0;
          else if (rank_q[up_idx][w] < rank_q[up_idx][fill_way])
            rank_q[up_idx][w] <= rank_q[up_idx][w] + WAY_W'(1);
        end
      end else if (up_kill) begin
        vld_q[up_idx][up_way] <= 1'b0;
      end
      if (lk_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == lk_way)
            rank_q[lk_idx][w] <= '0;
          else if (rank_q[lk_idx][w] < rank_q[lk_idx][lk_way])
            rank_q[lk_idx][w] <= rank_q[lk_idx][w] + WAY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/btb_cache_chk.sv
module btb_cache_chk #(
  parameter int ADDR_W    = 32,
  parameter bit INV_ON_NT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_use_dir,
  input logic              lk_dir_taken,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic [ADDR_W-1:0] lk_next_pc,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_pc,
  input logic              up_taken,
  input logic [ADDR_W-1:0] up_target
);
  a_r2_miss_falls_through: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken && lk_next_pc == lk_pc + ADDR_W'(4));

  a_r3_hit_alone_taken: assert property (@(posedge clk) disable iff (rst)
    lk_hit && !lk_use_dir |-> lk_taken && lk_next_pc == lk_target);

  a_r4_dir_vetoes_hit: assert property (@(posedge clk) disable iff (rst)
    lk_hit && lk_use_dir && !lk_dir_taken |-> !lk_taken && lk_next_pc == lk_pc + ADDR_W'(4));

  a_r5_install_visible: assert property (@(posedge clk) disable iff (rst)
    $past(up_valid && up_taken) && lk_valid && lk_pc == $past(up_pc)
      |-> lk_hit && lk_target == $past(up_target));

  a_r7_not_taken_clears: assert property (@(posedge clk) disable iff (rst)
    INV_ON_NT && $past(up_valid && !up_taken) && lk_valid && lk_pc == $past(up_pc)
      |-> !lk_hit);
endmodule

bind btb_cache btb_cache_chk #(.ADDR_W(ADDR_W), .INV_ON_NT(INV_ON_NT)) chk_i (.*);

// File: tb/btb_cache_tb_top.sv
module btb_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_use_dir = 1'b0, lk_dir_taken = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target, lk_next_pc;
  logic        up_valid = 1'b0, up_taken = 1'b0;
  logic [31:0] up_pc = '0, up_target = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    logic        hit;
    logic        taken;
    logic [31:0] nxt;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  btb_cache dut_i (.*);

  task automatic look(input logic [31:0] pc, input bit v, input bit ud, input bit dt,
                      input bit eh, input bit et, input logic [31:0] en, input string r);
    @(negedge clk);
    lk_valid = v; lk_pc = pc; lk_use_dir = ud; lk_dir_taken = dt;
    q.push_back('{r, eh, et, en});
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic hitchk(input logic [31:0] pc, input logic [31:0] tgt, input string r);
    look(pc, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, tgt, r);
  endtask

  task automatic misschk(input logic [31:0] pc, input string r);
    look(pc, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pc + 32'd4, r);
  endtask

  task automatic upd(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
    @(posedge clk);
    #1 up_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (lk_hit !== e.hit || lk_taken !== e.taken || lk_next_pc !== e.nxt) begin
          fails++;
          $display("FAIL %s: hit=%0b taken=%0b next=%h, expected hit=%0b taken=%0b next=%h",
                   e.req, lk_hit, lk_taken, lk_next_pc, e.hit, e.taken, e.nxt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    misschk(32'h1000, "R1");
    misschk(32'h0040, "R1");
    // R2 invalid lookup reads as miss
    look(32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1004, "R2");
    // R5 install, R3 standalone hit
    upd(32'h1000, 1'b1, 32'h8000);
    hitchk(32'h1000, 32'h8000, "R5");
    hitchk(32'h1000, 32'h8000, "R3");
    misschk(32'h1040, "R2");
    // R4 qualified mode
    look(32'h1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h1004, "R4");
    look(32'h1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h8000, "R4");
    // R6 rewrite target
    upd(32'h1000, 1'b1, 32'h9000);
    hitchk(32'h1000, 32'h9000, "R6");
    // R7 not-taken removes
    upd(32'h1000, 1'b0, 32'h0);
    misschk(32'h1000, "R7");
    // R8 four tags share set 0
    upd(32'h1000, 1'b1, 32'hA100);
    upd(32'h2000, 1'b1, 32'hA200);
    upd(32'h3000, 1'b1, 32'hA300);
    upd(32'h4000, 1'b1, 32'hA400);
    hitchk(32'h1000, 32'hA100, "R8");
    hitchk(32'h2000, 32'hA200, "R8");
    hitchk(32'h3000, 32'hA300, "R8");
    hitchk(32'h4000, 32'hA400, "R8");
    // R9 refresh 0x1000, so 0x2000 is least recent
    hitchk(32'h1000, 32'hA100, "R9");
    upd(32'h5000, 1'b1, 32'hA500);
    misschk(32'h2000, "R9");
    hitchk(32'h5000, 32'hA500, "R9");
    hitchk(32'h1000, 32'hA100, "R9");
    hitchk(32'h3000, 32'hA300, "R9");
    hitchk(32'h4000, 32'hA400, "R9");
    // R10 invalid way reused before the oldest valid one (set 2)
    upd(32'h1008, 1'b1, 32'hB100);
    upd(32'h2008, 1'b1, 32'hB200);
    upd(32'h3008, 1'b1, 32'hB300);
    upd(32'h4008, 1'b1, 32'hB400);
    upd(32'h2008, 1'b0, 32'h0);
    upd(32'h5008, 1'b1, 32'hB500);
    hitchk(32'h1008, 32'hB100, "R10");
    hitchk(32'h5008, 32'hB500, "R10");
    misschk(32'h2008, "R10");
    // R11 idle lookup does not refresh (set 3)
    upd(32'h100C, 1'b1, 32'hC100);
    upd(32'h200C, 1'b1, 32'hC200);
    upd(32'h300C, 1'b1, 32'hC300);
    upd(32'h400C, 1'b1, 32'hC400);
    look(32'h100C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1010, "R11");
    upd(32'h500C, 1'b1, 32'hC500);
    misschk(32'h100C, "R11");
    hitchk(32'h200C, 32'hC200, "R11");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule